// File: doc/BRIEF.md
# I2C Controller FIFO Pair with Occupancy and Watermark

This block holds the two data queues of an I2C controller. The transmit queue stores 10-bit entries: eight data bits plus two control bits for the bus engine. The register side writes these entries and the engine drains them. The receive queue stores bytes. The engine fills it and the register side reads it one byte per read.

Both queues report how full they are as a zero-based occupancy, which is the stored count minus one. They also drive four status flags and three interrupt sources. Interrupt masking and bus sequencing are handled elsewhere. The receive side compares its fill level against a programmable zero-based threshold. The transmit side reports when it is drained and when it is at most half full. A flush control empties the transmit queue without touching the receive queue.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Each queue holds 16 entries. A push while the queue is full is dropped. The full flag is status bit 4 for transmit and status bit 5 for receive.
- R2: `tx_occ_o` and `rx_occ_o` read as the stored count minus one, and read 0 when the queue is empty.
- R3: Entries leave a queue in the order they were written, and all 10 transmit bits are preserved.
- R4: Status bit 6 is high when the receive queue is empty, and status bit 7 is high when the transmit queue is empty. Status bits 3..0 always read 0.
- R5: Interrupt bit 3 is high while the receive queue holds more than `rx_wmark_i` entries, that is, at least `rx_wmark_i`+1 entries.
- R6: Interrupt bit 2 is high while the transmit queue is empty.
- R7: Interrupt bit 7 is high while the transmit queue holds 8 entries or fewer. Interrupt bits 6..4 and 1..0 read 0.
- R8: A cycle with `tx_flush_i` high empties the transmit queue by the next cycle. A push in that same cycle is dropped.
- R9: While a queue is empty, its read data is 0. A pop on the empty queue changes neither the occupancy nor the data that later pushes deliver.
- R10: After reset both queues are empty: status reads 0xC0, the interrupt sources read 0x84 for any threshold, and both occupancies read 0.
- R11: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave the occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_flush_i | input | 1 | Empty the transmit queue |
| tx_push_i | input | 1 | Write one transmit entry |
| tx_wdata_i | input | 10 | Transmit entry to write |
| tx_pop_i | input | 1 | Engine takes the head transmit entry |
| tx_rdata_o | output | 10 | Head transmit entry, 0 when empty |
| rx_push_i | input | 1 | Engine stores one received byte |
| rx_wdata_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Register read takes the head byte |
| rx_rdata_o | output | 8 | Head received byte, 0 when empty |
| rx_wmark_i | input | 4 | Zero-based receive threshold |
| tx_occ_o | output | 4 | Transmit occupancy, count minus one |
| rx_occ_o | output | 4 | Receive occupancy, count minus one |
| status_o | output | 8 | Queue flags: bit 4 TX full, bit 5 RX full, bit 6 RX empty, bit 7 TX empty |
| irq_o | output | 8 | Event sources: bit 2 TX empty, bit 3 RX threshold, bit 7 TX half empty |

## Verification
A corrupt count shows up in the same cycle on the occupancy, the flags and the interrupt sources, because all of them are decoded from that count. A single step off is visible at the next sample. A corrupt pointer leaves the flags consistent, but it returns wrong or reordered data at the next pop. The scoreboard catches this as soon as the affected entry reaches the head. The stress points are a full queue, an empty queue, the half-depth boundary and the threshold boundary. At these points a dropped or doubled push shows up as an off-by-one occupancy.

// File: rtl/i2c_fifo_pkg.sv
`timescale 1ns/1ps
package i2c_fifo_pkg;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_RX_EMPTY = 6;
  localparam int ST_TX_EMPTY = 7;
  localparam int EV_TX_EMPTY = 2;
  localparam int EV_RX_WMARK = 3;
  localparam int EV_TX_HALF  = 7;
endpackage

// File: rtl/i2c_fifo_buf.sv
`timescale 1ns/1ps
module i2c_fifo_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/i2c_fifo_level.sv
`timescale 1ns/1ps
module i2c_fifo_level #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] thresh_i,
  output logic [AW-1:0] occ_o,
  output logic          above_o
);
  // zero-based occupancy; empty and one entry both read 0
  assign occ_o   = (count_i == '0) ? '0 : AW'(count_i - 1'b1);
  assign above_o = (count_i > {1'b0, thresh_i});
endmodule

// File: rtl/i2c_fifo_pair.sv
`timescale 1ns/1ps
module i2c_fifo_pair
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TX_W  = 10,
  parameter int RX_W  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_flush_i,
  input  logic            tx_push_i,
  input  logic [TX_W-1:0] tx_wdata_i,
  input  logic            tx_pop_i,
  output logic [TX_W-1:0] tx_rdata_o,
  input  logic            rx_push_i,
  input  logic [RX_W-1:0] rx_wdata_i,
  input  logic            rx_pop_i,
  output logic [RX_W-1:0] rx_rdata_o,
  input  logic [AW-1:0]   rx_wmark_i,
  output logic [AW-1:0]   tx_occ_o,
  output logic [AW-1:0]   rx_occ_o,
  output logic [7:0]      status_o,
  output logic [7:0]      irq_o
);
  localparam logic [AW-1:0] HALF_THR = AW'(DEPTH / 2);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_above_half, rx_above_wm;

  i2c_fifo_buf #(.W(TX_W), .DEPTH(DEPTH)) u_tx_buf (
    .clk_i, .rst_ni,
    .flush_i (tx_flush_i),
    .push_i  (tx_push_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_rdata_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  i2c_fifo_buf #(.W(RX_W), .DEPTH(DEPTH)) u_rx_buf (
    .clk_i, .rst_ni,
    .flush_i (1'b0),
    .push_i  (rx_push_i),
    .wdata_i (rx_wdata_i),
    .pop_i   (rx_pop_i),
    .rdata_o (rx_rdata_o),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  // half-empty is the complement of "above DEPTH/2"
  i2c_fifo_level #(.DEPTH(DEPTH)) u_tx_lvl (
    .count_i  (tx_cnt),
    .thresh_i (HALF_THR),
    .occ_o    (tx_occ_o),
    .above_o  (tx_above_half)
  );

  i2c_fifo_level #(.DEPTH(DEPTH)) u_rx_lvl (
    .count_i  (rx_cnt),
    .thresh_i (rx_wmark_i),
    .occ_o    (rx_occ_o),
    .above_o  (rx_above_wm)
  );

  always_comb begin
    status_o              = '0;
    status_o[ST_TX_FULL]  = tx_full;
    status_o[ST_RX_FULL]  = rx_full;
    status_o[ST_RX_EMPTY] = rx_empty;
    status_o[ST_TX_EMPTY] = tx_empty;
    irq_o                 = '0;
    irq_o[EV_TX_EMPTY]    = tx_empty;
    irq_o[EV_RX_WMARK]    = rx_above_wm;
    irq_o[EV_TX_HALF]     = !tx_above_half;
  end
endmodule

// File: rtl/i2c_fifo_pair_chk.sv
`timescale 1ns/1ps
module i2c_fifo_pair_chk #(
  parameter int TX_W = 10,
  parameter int RX_W = 8,
  parameter int AW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_flush_i,
  input logic            tx_push_i,
  input logic            tx_pop_i,
  input logic            rx_push_i,
  input logic            rx_pop_i,
  input logic [RX_W-1:0] rx_rdata_o,
  input logic [TX_W-1:0] tx_rdata_o,
  input logic [AW-1:0]   tx_occ_o,
  input logic [AW-1:0]   rx_occ_o,
  input logic [7:0]      status_o,
  input logic [7:0]      irq_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] && tx_push_i && !tx_pop_i && !tx_flush_i |=> status_o[4] && $stable(tx_occ_o)); // R1
  AST_RX_OCC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> rx_occ_o == '0); // R2
  AST_TX_OCC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> tx_occ_o == '0); // R2
  AST_LOW_STATUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:0] == 4'h0); // R4
  AST_WMARK_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[3] |-> !status_o[6]); // R5
  AST_TX_EMPTY_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] == status_o[7]); // R6
  AST_HALF_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] |-> irq_o[7]); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_i |=> status_o[7] && tx_occ_o == '0); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] && rx_pop_i && !rx_push_i |=> status_o[6]); // R9
  AST_EMPTY_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> rx_rdata_o == '0); // R9
  AST_TX_EMPTY_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> tx_rdata_o == '0); // R9
  AST_PUSH_POP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[6] && !status_o[5] && rx_push_i && rx_pop_i |=> $stable(rx_occ_o)); // R11
endmodule

bind i2c_fifo_pair i2c_fifo_pair_chk #(.TX_W(TX_W), .RX_W(RX_W), .AW(AW)) chk_i (
  .clk_i, .rst_ni, .tx_flush_i, .tx_push_i, .tx_pop_i, .rx_push_i, .rx_pop_i,
  .rx_rdata_o, .tx_rdata_o, .tx_occ_o, .rx_occ_o, .status_o, .irq_o
);

// File: tb/i2c_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module i2c_fifo_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_flush = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [9:0] tx_wdata = '0, tx_rdata;
  logic [7:0] rx_wdata = '0, rx_rdata;
  logic [3:0] wmark = 4'd3, tx_occ, rx_occ;
  logic [7:0] status, irq;

  int n_tests = 0, n_fail = 0;
  int tx_cnt = 0, rx_cnt = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk = ~clk;

  i2c_fifo_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_flush_i(tx_flush), .tx_push_i(tx_push),
    .tx_wdata_i(tx_wdata), .tx_pop_i(tx_pop), .tx_rdata_o(tx_rdata),
    .rx_push_i(rx_push), .rx_wdata_i(rx_wdata), .rx_pop_i(rx_pop),
    .rx_rdata_o(rx_rdata), .rx_wmark_i(wmark), .tx_occ_o(tx_occ),
    .rx_occ_o(rx_occ), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] occ_of(input int c);
    return (c == 0) ? 4'd0 : 4'(c - 1);
  endfunction

  task automatic check_levels(input string tag);
    logic [7:0] st, ev;
    st = {tx_cnt == 0, rx_cnt == 0, rx_cnt == 16, tx_cnt == 16, 4'h0};
    ev = {tx_cnt <= 8, 3'b000, rx_cnt > int'(wmark), tx_cnt == 0, 2'b00};
    chk({"R2 tx occ ", tag}, 32'(tx_occ), 32'(occ_of(tx_cnt)));
    chk({"R2 rx occ ", tag}, 32'(rx_occ), 32'(occ_of(rx_cnt)));
    chk({"R1 R4 status ", tag}, 32'(status), 32'(st));
    chk({"R5 R6 R7 irq ", tag}, 32'(irq), 32'(ev));
  endtask

  // scoreboard driver: push on the bus, record expectation when accepted
  task automatic tx_put(input logic [9:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d;
    @(negedge clk); tx_push = 0;
    if (tx_cnt < 16) begin txq.push_back(d); tx_cnt++; end
  endtask

  task automatic rx_put(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_wdata = d;
    @(negedge clk); rx_push = 0;
    if (rx_cnt < 16) begin rxq.push_back(d); rx_cnt++; end
  endtask

  // scoreboard monitor: compare head against queue, then pop
  task automatic tx_get(input string req);
    logic [9:0] e;
    @(negedge clk);
    e = (txq.size() > 0) ? txq.pop_front() : 10'h0;
    chk({req, " tx data"}, 32'(tx_rdata), 32'(e));
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    if (tx_cnt > 0) tx_cnt--;
  endtask

  task automatic rx_get(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h0;
    chk({req, " rx data"}, 32'(rx_rdata), 32'(e));
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    if (rx_cnt > 0) rx_cnt--;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 status", 32'(status), 32'h0C0);
    chk("R10 irq", 32'(irq), 32'h084);
    check_levels("R10 reset");

    // R1 R3 R7: fill transmit, overflow, drain in order
    for (int i = 0; i < 16; i++) begin
      tx_put((i == 15) ? 10'h3FF : 10'((i * 37 + 5) | ((i & 3) << 8)));
      check_levels("R1 R7 tx fill");
    end
    tx_put(10'h155);
    check_levels("R1 tx overflow");
    for (int i = 0; i < 16; i++) begin
      tx_get("R3");
      check_levels("R3 R7 tx drain");
    end

    // R9 pop on empty
    tx_get("R9 empty");
    rx_get("R9 empty");
    check_levels("R9 after empty pop");
    rx_put(8'hA5);
    tx_put(10'h2C3);
    check_levels("R9 one entry");
    rx_get("R9");
    tx_get("R9");

    // R8 flush with simultaneous push
    for (int i = 0; i < 5; i++) tx_put(10'(i + 10'h100));
    @(negedge clk); tx_flush = 1; tx_push = 1; tx_wdata = 10'h0AA;
    @(negedge clk); tx_flush = 0; tx_push = 0;
    txq.delete(); tx_cnt = 0;
    check_levels("R8 flush");
    tx_put(10'h201); tx_put(10'h0F0);
    tx_get("R8 after flush"); tx_get("R8 after flush");

    // R5 threshold, R1 receive full
    wmark = 4'd3;
    for (int i = 0; i < 4; i++) begin
      rx_put(8'(8'h40 + i));
      check_levels("R5 wm3");
    end
    wmark = 4'd0; @(negedge clk);
    check_levels("R5 wm0");
    for (int i = 4; i < 17; i++) rx_put(8'(8'h40 + i));
    check_levels("R1 rx full");
    wmark = 4'd15; @(negedge clk);
    check_levels("R5 wm15 full");
    rx_get("R3 R5");
    check_levels("R5 wm15 below");

    // R11 simultaneous push and pop
    begin
      logic [7:0] e;
      @(negedge clk);
      e = rxq.pop_front();
      chk("R11 rx data", 32'(rx_rdata), 32'(e));
      rx_push = 1; rx_pop = 1; rx_wdata = 8'hE7;
      @(negedge clk); rx_push = 0; rx_pop = 0;
      rxq.push_back(8'hE7);
      check_levels("R11 push pop");
    end
    while (rx_cnt > 0) rx_get("R11 R3 drain");
    check_levels("R11 drained");

    finish_run();
  end
endmodule